// File: doc/BRIEF.md
# Single-Byte Serial Peripheral Interface Master

This block is the master side of a synchronous serial link that moves one byte per transfer. Software-style control inputs choose the idle level of the serial clock, the edge on which data is sampled, and the serial clock rate. The rate is picked by a two-bit rate code together with a double-speed bit. A write to the data input starts a transfer. While the transfer runs, the byte is shifted out on `mosi`, most significant bit first. At the same time the peer's byte is captured from `miso`. When the transfer ends, the received byte is presented on `data_out` and a completion flag is raised. The flag stays up until it is acknowledged.

An active-low select-sense input guards the bus against a second master. If it goes low while master operation is enabled, the block aborts any transfer in progress and returns the serial clock to its idle level. It also drops master operation and raises the completion flag. Master operation does not come back until the enable is written again. A data write made while a byte is still moving does not disturb that byte. It raises a write-collision flag instead.

Top module: `spi_master_core`

## Requirements
- R1: After reset, `sck` is 0, `cs_n` is 1, `busy` is 0, and `master_en`, `done_flag` and `wcol_flag` are all 0.
- R2: Write the 3-bit code {`ctl_dbl`, `ctl_rate`} as {bit, two bits}. The codes 000, 001, 010 and 011 divide the clock by 4, 16, 64 and 128. The codes 100, 101, 110 and 111 divide it by 2, 8, 32 and 64. A byte therefore takes 8×divisor clock cycles. Counting the clock edge that accepts the data write as cycle 1, `done_flag` is first seen high after cycle 8×divisor+1.
- R3: While idle, `sck` rests at the selected polarity (0 gives a low idle level, 1 gives a high one). Each byte produces exactly 16 `sck` transitions. The first transition (the leading edge) moves away from the idle level.
- R4: With phase 0, the first data bit is on `mosi` as soon as the transfer starts. `miso` is sampled on leading edges and `mosi` changes on trailing edges. With phase 1, `mosi` changes on leading edges and `miso` is sampled on trailing edges. Bits move most significant first. After the transfer, `data_out` holds the byte received on `miso`.
- R5: `done_flag` sets when a byte completes and stays set until `flag_ack` is pulsed. On the cycle after a completion, `done_flag` is 1.
- R6: A data write while `master_en` is 0 starts nothing: `cs_n` stays 1, `busy` stays 0 and `done_flag` stays 0.
- R7: A data write while `busy` is 1 leaves the byte in flight unchanged and sets `wcol_flag` on the next cycle. `flag_ack` clears `wcol_flag`.
- R8: If `ss_sense_n` is 0 while `master_en` is 1, then on the next cycle `master_en` is 0, `done_flag` is 1, `busy` is 0, `cs_n` is 1 and `sck` is at the idle level.
- R9: `ss_sense_n` low has no effect while `master_en` is 0: `done_flag` stays 0.
- R10: A control write during a transfer changes neither the polarity, the phase nor the rate of that transfer. It takes effect once the block is idle.
- R11: `cs_n` is 0 exactly while a transfer is in progress.
- R12: A mode fault seen on the same clock as the final `sck` edge leaves `master_en` 0, `done_flag` 1, `busy` 0, `sck` idle and `wcol_flag` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en | input | 1 | Master enable value written by `ctl_wr` |
| ctl_cpol | input | 1 | Clock idle level value |
| ctl_cpha | input | 1 | Clock phase value |
| ctl_dbl | input | 1 | Double-speed bit |
| ctl_rate | input | 2 | Rate code |
| data_wr | input | 1 | Data write strobe; starts a transfer |
| data_in | input | DATA_W | Byte to send |
| flag_ack | input | 1 | Clears the completion and collision flags |
| ss_sense_n | input | 1 | Active-low mode-fault sense |
| miso | input | 1 | Serial data from the peer |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peer |
| cs_n | output | 1 | Active-low select, low during a transfer |
| data_out | output | DATA_W | Received byte |
| master_en | output | 1 | Master operation enabled |
| done_flag | output | 1 | Transfer complete (or mode fault) |
| wcol_flag | output | 1 | Write collision |
| busy | output | 1 | Transfer in progress |

## Verification
The completing edge of a byte and a mode fault can fall on the same clock. On that clock the normal end of transfer tries to raise the flag and leave the clock idle, while the fault path tries to abort the shift and clear the enable. The bench provokes this by counting clock cycles from the data write and pulling `ss_sense_n` low so that it is sampled on exactly the clock of the sixteenth edge. It then checks that the enable is cleared, the flag is set exactly once, the clock rests idle and no collision is reported.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

   // Active transfer settings.
   typedef struct packed {
      logic       cpol;
      logic       cpha;
      logic       dbl;
      logic [1:0] rate;
   } spi_cfg_t;

   // Largest divisor is 2**RATE_EXP_MAX.
   localparam int unsigned RATE_EXP_MAX = 7;

   // Exponent of the half period (in clocks) for a rate code.
   // Normal speed: 4,16,64,128 -> half 2,8,32,64.
   // Double speed halves each one.
   function automatic logic [2:0] half_exp(input logic dbl, input logic [1:0] rate);
      logic [2:0] e;
      case (rate)
         2'd0:    e = 3'd1;
         2'd1:    e = 3'd3;
         2'd2:    e = 3'd5;
         default: e = 3'd6;
      endcase
      if (dbl) e = e - 3'd1;
      return e;
   endfunction

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
   parameter int unsigned CNT_W = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] hexp,
   output logic       tick
);
   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   // The half period is 2**hexp clocks, so the counter wraps at that value minus one.
   assign limit = ({{(CNT_W-1){1'b0}}, 1'b1} << hexp) - {{(CNT_W-1){1'b0}}, 1'b1};
   assign tick  = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          LSB_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              lead_tick,
   input  logic              trail_tick,
   input  logic              cpha,
   input  logic              miso,
   output logic              mosi,
   output logic [DATA_W-1:0] rx_data
);
   logic [DATA_W-1:0] sh_q;
   logic              rx_bit_q;
   logic              mosi_q;
   logic              out_bit;
   logic              load_bit;
   logic [DATA_W-1:0] sh_in_cap;
   logic [DATA_W-1:0] sh_in_live;

   // The bit order is chosen at elaboration.
   generate
      if (LSB_FIRST) begin : g_lsb
         assign out_bit    = sh_q[0];
         assign load_bit   = load_data[0];
         assign sh_in_cap  = {rx_bit_q, sh_q[DATA_W-1:1]};
         assign sh_in_live = {miso, sh_q[DATA_W-1:1]};
      end else begin : g_msb
         assign out_bit    = sh_q[DATA_W-1];
         assign load_bit   = load_data[DATA_W-1];
         assign sh_in_cap  = {sh_q[DATA_W-2:0], rx_bit_q};
         assign sh_in_live = {sh_q[DATA_W-2:0], miso};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q     <= '0;
         rx_bit_q <= 1'b0;
         mosi_q   <= 1'b0;
      end else if (load) begin
         sh_q   <= load_data;
         mosi_q <= load_bit;
      end else if (!cpha) begin
         // Phase 0: capture on the leading edge, shift on the trailing edge.
         if (lead_tick)  rx_bit_q <= miso;
         if (trail_tick) sh_q     <= sh_in_cap;
      end else begin
         // Phase 1: present a bit on the leading edge, capture on the trailing edge.
         if (lead_tick)  mosi_q <= out_bit;
         if (trail_tick) sh_q   <= sh_in_live;
      end
   end

   assign mosi    = cpha ? mosi_q : out_bit;
   assign rx_data = sh_q;
endmodule

// File: rtl/spi_ctrl_regs.sv
module spi_ctrl_regs
   import spi_master_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ctl_wr,
   input  logic     ctl_en,
   input  spi_cfg_t cfg_in,
   input  logic     fault,
   input  logic     busy,
   input  logic     complete,
   input  logic     data_wr,
   input  logic     flag_ack,
   output logic     master_en,
   output spi_cfg_t act_cfg,
   output logic     done_flag,
   output logic     wcol_flag
);
   spi_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q     <= '0;
         act_cfg   <= '0;
         master_en <= 1'b0;
         done_flag <= 1'b0;
         wcol_flag <= 1'b0;
      end else begin
         if (ctl_wr) cfg_q <= cfg_in;
         // The live settings follow the control value only while no byte is moving.
         if (!busy) act_cfg <= ctl_wr ? cfg_in : cfg_q;

         // A fault takes priority over a software write of the enable.
         if (fault)       master_en <= 1'b0;
         else if (ctl_wr) master_en <= ctl_en;

         // Setting the flags takes priority over an acknowledge.
         if (complete || fault) done_flag <= 1'b1;
         else if (flag_ack)     done_flag <= 1'b0;

         if (data_wr && busy) wcol_flag <= 1'b1;
         else if (flag_ack)   wcol_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
   import spi_master_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter bit          LSB_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              ctl_en,
   input  logic              ctl_cpol,
   input  logic              ctl_cpha,
   input  logic              ctl_dbl,
   input  logic [1:0]        ctl_rate,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_in,
   input  logic              flag_ack,
   input  logic              ss_sense_n,
   input  logic              miso,
   output logic              sck,
   output logic              mosi,
   output logic              cs_n,
   output logic [DATA_W-1:0] data_out,
   output logic              master_en,
   output logic              done_flag,
   output logic              wcol_flag,
   output logic              busy
);
   localparam int unsigned     EDGE_W    = $clog2(2 * DATA_W);
   localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DATA_W - 1);
   localparam int unsigned     CNT_W     = RATE_EXP_MAX - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
   endgenerate

   spi_cfg_t          cfg_in;
   spi_cfg_t          act_cfg;
   logic              fault;
   logic              abort;
   logic              start;
   logic              tick;
   logic              step;
   logic              lead_tick;
   logic              trail_tick;
   logic              complete;
   logic              busy_q;
   logic              sck_q;
   logic [EDGE_W-1:0] edge_q;
   logic [2:0]        hexp;

   assign cfg_in     = '{cpol: ctl_cpol, cpha: ctl_cpha, dbl: ctl_dbl, rate: ctl_rate};
   assign fault      = master_en && !ss_sense_n;
   assign abort      = fault || (busy_q && ctl_wr && !ctl_en);
   assign start      = data_wr && master_en && !busy_q && !abort;
   assign hexp       = half_exp(act_cfg.dbl, act_cfg.rate);
   assign step       = busy_q && tick && !abort;
   assign lead_tick  = step && !edge_q[0];
   assign trail_tick = step && edge_q[0];
   assign complete   = trail_tick && (edge_q == LAST_EDGE);

   spi_ctrl_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .ctl_en    (ctl_en),
      .cfg_in    (cfg_in),
      .fault     (fault),
      .busy      (busy_q),
      .complete  (complete),
      .data_wr   (data_wr),
      .flag_ack  (flag_ack),
      .master_en (master_en),
      .act_cfg   (act_cfg),
      .done_flag (done_flag),
      .wcol_flag (wcol_flag)
   );

   spi_rate_gen #(.CNT_W(CNT_W)) u_rate (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy_q),
      .hexp  (hexp),
      .tick  (tick)
   );

   spi_shift_unit #(.DATA_W(DATA_W), .LSB_FIRST(LSB_FIRST)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (start),
      .load_data  (data_in),
      .lead_tick  (lead_tick),
      .trail_tick (trail_tick),
      .cpha       (act_cfg.cpha),
      .miso       (miso),
      .mosi       (mosi),
      .rx_data    (data_out)
   );

   // Sequencer: counts the clock edges and holds the serial clock level.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sck_q  <= 1'b0;
         edge_q <= '0;
      end else if (abort) begin
         busy_q <= 1'b0;
         edge_q <= '0;
         sck_q  <= act_cfg.cpol;
      end else if (start) begin
         busy_q <= 1'b1;
         edge_q <= '0;
      end else if (step) begin
         sck_q  <= ~sck_q;
         edge_q <= edge_q + 1'b1;
         if (edge_q == LAST_EDGE) busy_q <= 1'b0;
      end else if (!busy_q) begin
         sck_q <= act_cfg.cpol;
      end
   end

   assign sck  = sck_q;
   assign cs_n = ~busy_q;
   assign busy = busy_q;
endmodule

// File: rtl/spi_master_checks.sv
module spi_master_checks
   import spi_master_pkg::*;
(
   input logic     clk,
   input logic     rst_n,
   input logic     busy,
   input logic     sck,
   input logic     master_en,
   input logic     done_flag,
   input logic     wcol_flag,
   input logic     ss_sense_n,
   input logic     data_wr,
   input spi_cfg_t act_cfg
);
   // R8: a fault while enabled drops the enable and raises the flag.
   assert_fault_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (master_en && !ss_sense_n) |=> (!master_en && done_flag && !busy));

   // R7: a data write during a transfer raises the collision flag.
   assert_wcol_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && data_wr) |=> wcol_flag);

   // R10: the live settings hold still across a transfer.
   assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> $stable(act_cfg));

   // R3: the serial clock rests at the live idle level when no byte moves.
   assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(busy) |-> (sck == $past(act_cfg.cpol)));

   // R5: the completion flag rises only after a transfer or through a fault.
   assert_done_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> ($past(busy) || !master_en));
endmodule

bind spi_master_core spi_master_checks u_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy_q),
   .sck        (sck),
   .master_en  (master_en),
   .done_flag  (done_flag),
   .wcol_flag  (wcol_flag),
   .ss_sense_n (ss_sense_n),
   .data_wr    (data_wr),
   .act_cfg    (act_cfg)
);

// File: tb/test_spi_master_core.sv
module test_spi_master_core;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0, ctl_en = 1'b0, ctl_cpol = 1'b0, ctl_cpha = 1'b0, ctl_dbl = 1'b0;
   logic [1:0] ctl_rate = 2'd0;
   logic       data_wr = 1'b0;
   logic [7:0] data_in = 8'h00;
   logic       flag_ack = 1'b0;
   logic       ss_sense_n = 1'b1;
   logic       miso;
   logic       sck, mosi, cs_n, master_en, done_flag, wcol_flag, busy;
   logic [7:0] data_out;

   int n_chk = 0;
   int n_fail = 0;

   // Peer model.
   logic [7:0] s_tx = 8'h00, s_rx = 8'h00;
   logic       s_hold = 1'b0;
   logic       b_cpol = 1'b0, b_cpha = 1'b0;
   logic       slv_active = 1'b0;
   int         edge_seen = 0;

   always #5 clk = ~clk;

   spi_master_core i_spi_master_core (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_cpol(ctl_cpol),
      .ctl_cpha(ctl_cpha), .ctl_dbl(ctl_dbl), .ctl_rate(ctl_rate), .data_wr(data_wr),
      .data_in(data_in), .flag_ack(flag_ack), .ss_sense_n(ss_sense_n), .miso(miso),
      .sck(sck), .mosi(mosi), .cs_n(cs_n), .data_out(data_out), .master_en(master_en),
      .done_flag(done_flag), .wcol_flag(wcol_flag), .busy(busy)
   );

   assign miso = b_cpha ? s_hold : s_tx[7];

   always @(sck) begin
      if (slv_active) begin
         edge_seen++;
         if (sck != b_cpol) begin
            if (b_cpha) begin s_hold = s_tx[7]; s_tx = {s_tx[6:0], 1'b0}; end
            else s_rx = {s_rx[6:0], mosi};
         end else begin
            if (b_cpha) s_rx = {s_rx[6:0], mosi};
            else s_tx = {s_tx[6:0], 1'b0};
         end
      end
   end

   // Each entry is {dbl, rate, cpol, cpha, tx, peer_tx}.
   localparam logic [20:0] VEC [0:7] = '{
      {1'b0, 2'b00, 1'b0, 1'b0, 8'hA5, 8'h3C},
      {1'b0, 2'b01, 1'b0, 1'b1, 8'h5A, 8'hC3},
      {1'b0, 2'b10, 1'b1, 1'b0, 8'h81, 8'h7E},
      {1'b0, 2'b11, 1'b1, 1'b1, 8'h00, 8'hFF},
      {1'b1, 2'b00, 1'b0, 1'b0, 8'hFF, 8'h00},
      {1'b1, 2'b01, 1'b1, 1'b1, 8'h96, 8'h69},
      {1'b1, 2'b10, 1'b0, 1'b1, 8'h3C, 8'hA5},
      {1'b1, 2'b11, 1'b1, 1'b0, 8'hE7, 8'h18}
   };

   function automatic int divisor(input logic dbl, input logic [1:0] rate);
      int d;
      case (rate)
         2'd0: d = 4;
         2'd1: d = 16;
         2'd2: d = 64;
         default: d = 128;
      endcase
      return dbl ? d / 2 : d;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_cfg(input logic en, input logic cp, input logic ph,
                            input logic dbl, input logic [1:0] rate);
      @(negedge clk);
      ctl_wr = 1'b1; ctl_en = en; ctl_cpol = cp; ctl_cpha = ph; ctl_dbl = dbl; ctl_rate = rate;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic ack();
      @(negedge clk); flag_ack = 1'b1;
      @(negedge clk); flag_ack = 1'b0;
   endtask

   // Runs one byte. A negative *_at leaves that event out.
   // cfg_at: control write flipping the polarity to 1; fault_at: ss low; wr_at: data write.
   task automatic xfer(input logic [7:0] tx, input logic [7:0] stx, input logic cp, input logic ph,
                       input int cfg_at, input int fault_at, input int wr_at, output int cyc);
      int cnt;
      s_tx = stx; s_rx = 8'h00; s_hold = 1'b0; b_cpol = cp; b_cpha = ph;
      edge_seen = 0; slv_active = 1'b1;
      @(negedge clk);
      data_in = tx; data_wr = 1'b1;
      cnt = 0;
      while (cnt < 3000) begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
         data_wr    = (cnt == wr_at);
         data_in    = 8'h00;
         ctl_wr     = (cnt == cfg_at);
         ctl_cpol   = (cnt == cfg_at) ? 1'b1 : ctl_cpol;
         ss_sense_n = (cnt == fault_at) ? 1'b0 : 1'b1;
         if (cnt == 2) check("R11 cs_n low during transfer", {cs_n, busy}, 2'b01);
         if (done_flag) break;
      end
      data_wr = 1'b0; ctl_wr = 1'b0; ss_sense_n = 1'b1;
      slv_active = 1'b0;
      cyc = cnt;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      int cyc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset outputs", {sck, cs_n, busy, master_en, done_flag, wcol_flag}, 6'b010000);

      // Sweep of the rate codes and the four modes.
      for (int i = 0; i < 8; i++) begin
         logic [20:0] v;
         int d;
         v = VEC[i];
         d = divisor(v[20], v[19:18]);
         write_cfg(1'b1, v[17], v[16], v[20], v[19:18]);
         repeat (2) @(negedge clk);
         check("R3 idle level before transfer", sck, v[17]);
         xfer(v[15:8], v[7:0], v[17], v[16], -1, -1, -1, cyc);
         check("R2 transfer length", cyc, 8 * d + 1);
         check("R3 sixteen sck edges", edge_seen, 16);
         check("R4 peer received byte", s_rx, v[15:8]);
         check("R4 master received byte", data_out, v[7:0]);
         check("R5 done set", done_flag, 1'b1);
         @(negedge clk);
         check("R3 idle level after transfer", sck, v[17]);
         ack();
         check("R5 done cleared by ack", done_flag, 1'b0);
      end

      // R6: data write while disabled.
      write_cfg(1'b0, 1'b0, 1'b0, 1'b0, 2'd0);
      @(negedge clk); data_in = 8'h55; data_wr = 1'b1;
      @(negedge clk); data_wr = 1'b0;
      repeat (3) @(negedge clk);
      check("R6 no transfer when disabled", {cs_n, busy, done_flag}, 3'b100);

      // R9: fault sense ignored while disabled.
      @(negedge clk); ss_sense_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R9 fault ignored when disabled", {done_flag, master_en}, 2'b00);
      ss_sense_n = 1'b1;

      // R7: write collision leaves the byte intact.
      write_cfg(1'b1, 1'b0, 1'b0, 1'b0, 2'd1);
      xfer(8'hC6, 8'h2D, 1'b0, 1'b0, -1, -1, 10, cyc);
      check("R7 collision flag set", wcol_flag, 1'b1);
      check("R7 byte in flight unchanged", s_rx, 8'hC6);
      check("R7 received byte", data_out, 8'h2D);
      ack();
      check("R7 collision cleared by ack", wcol_flag, 1'b0);

      // R10: a polarity change mid-transfer is deferred.
      xfer(8'h4B, 8'hB4, 1'b0, 1'b0, 40, -1, -1, cyc);
      check("R10 rate unchanged", cyc, 8 * 16 + 1);
      check("R10 edges unchanged", edge_seen, 16);
      check("R10 byte unchanged", s_rx, 8'h4B);
      repeat (3) @(negedge clk);
      check("R10 new idle level applied when idle", sck, 1'b1);
      ack();

      // R8: fault in the middle of a transfer.
      write_cfg(1'b1, 1'b1, 1'b1, 1'b0, 2'd1);
      xfer(8'h33, 8'hCC, 1'b1, 1'b1, -1, 20, -1, cyc);
      check("R8 aborted on next cycle", cyc, 21);
      check("R8 state after fault", {master_en, done_flag, busy, cs_n, sck}, 5'b01011);
      ack();

      // R12: fault on the clock of the final edge (divisor 4, half period 2).
      write_cfg(1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
      xfer(8'h0F, 8'hF0, 1'b0, 1'b0, -1, 32, -1, cyc);
      check("R12 coincident fault timing", cyc, 33);
      check("R12 state after coincident fault", {master_en, done_flag, busy, cs_n, sck, wcol_flag}, 6'b010100);
      ack();

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule